// File: doc/BRIEF.md
# Receive FIFO Drain Request Controller

This block decides when the receive path must take the system bus to move data out of the receive FIFO, and how long it keeps the bus once it has it. It watches the FIFO occupancy reported by the FIFO, in units of the selected transfer width. It compares that occupancy with a threshold picked by a 2-bit code. It then raises a bus request towards the bus cycle sequencer. The sequencer performs the memory writes and reports each completed one-unit transfer back to the block.

There are two drain policies. In drain-to-empty mode the burst continues until the FIFO holds nothing. In fixed-burst mode every burst moves exactly the threshold number of units and then gives the bus up. In both modes the burst stops early if the FIFO runs dry, so a transfer is never granted against an empty FIFO. The unit is a 16-bit word or a 32-bit long word, chosen by a width bit. The thresholds scale so that each code stands for the same number of bytes in both widths.

The controller has three states. ST_IDLE waits for the occupancy to reach the threshold and moves to ST_REQ. ST_REQ holds the bus request until the first transfer completes. From there it moves to ST_BURST, or straight back to ST_IDLE if that transfer already ended the burst. ST_BURST allows further transfers and returns to ST_IDLE when the burst ends. The FIFO occupancy reaching zero in ST_REQ or ST_BURST also forces a return to ST_IDLE.

Top module: `rx_drain_sched`

## Requirements
- R1: The threshold code `thr_sel` maps to a threshold in units. With `wide_unit`=0 (16-bit words), codes 0,1,2,3 give 2, 4, 8 and 12 units. With `wide_unit`=1 (32-bit long words), they give 1, 2, 4 and 6 units.
- R2: In ST_IDLE, `bus_req` rises one clock after `fifo_level` is at or above the threshold, and it stays low while `fifo_level` is below the threshold.
- R3: `bus_req` stays high, with no time limit, until the first transfer of the burst is acknowledged (`xfer_ack`=1 while `xfer_en`=1). It is low from the clock edge of that acknowledge onwards.
- R4: `xfer_en` is high in ST_REQ and ST_BURST whenever `fifo_level` is non-zero, and low in ST_IDLE.
- R5: With `blk_mode`=1, a burst ends after exactly threshold acknowledged transfers, provided the FIFO does not empty first.
- R6: With `blk_mode`=0, a burst continues until the transfer that takes the last unit, which is a transfer acknowledged while `fifo_level`=1.
- R7: With `blk_mode`=1, a burst whose FIFO empties before the threshold count is reached ends on the transfer acknowledged while `fifo_level`=1.
- R8: If `fifo_level` is 0 in ST_REQ or ST_BURST, `xfer_en` is low at once, `burst_end` is high in that cycle, and the controller is in ST_IDLE after the next edge.
- R9: After a burst ends, `bus_req` is low for at least one clock. A new request is raised only if `fifo_level` is again at or above the threshold.
- R10: `burst_end` is high, combinationally, in the cycle of the acknowledge that completes a burst, and low during acknowledges that do not complete one.
- R11: While `rst_n` is low, the controller is in ST_IDLE and `bus_req`, `xfer_en` and `burst_end` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_sel | input | 2 | Threshold code |
| blk_mode | input | 1 | 1: fixed-size bursts, 0: drain until empty |
| wide_unit | input | 1 | 1: 32-bit units, 0: 16-bit units |
| fifo_level | input | LVL_W (6) | FIFO occupancy in units |
| xfer_ack | input | 1 | One unit transfer completed this cycle |
| bus_req | output | 1 | Bus request to the sequencer |
| xfer_en | output | 1 | A unit transfer may be performed this cycle |
| burst_end | output | 1 | The burst finishes in this cycle |

## Verification
`xfer_en` and `burst_end` are combinational, so the bench checks them one time step after it drives `xfer_ack` or `fifo_level`, before the clock edge. `bus_req` comes from the state register, so it is due one edge after the threshold is crossed or the first acknowledge is seen, and the bench samples it one step after that edge. The bench mirrors the FIFO itself: each acknowledged transfer lowers `fifo_level` by one after the edge. It sweeps every combination of threshold code, width and mode, and computes the expected threshold, burst length and re-request decision from the tables above.

// File: rtl/rx_drain_pkg.sv
package rx_drain_pkg;
    localparam int THR_W = 4;          // holds the largest threshold, 12
    localparam int MAX_THR = 12;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_BURST = 2'd2
    } drain_state_e;
endpackage

// File: rtl/rx_drain_thresh.sv
module rx_drain_thresh
    import rx_drain_pkg::*;
(
    input  logic [1:0]       sel,
    input  logic             wide,
    output logic [THR_W-1:0] thr
);
    logic [THR_W-1:0] narrow_thr;

    // R1: 16-bit steps 2,4,8,12; 32-bit steps are half as many units
    always_comb begin
        unique case (sel)
            2'd0: narrow_thr = THR_W'(2);
            2'd1: narrow_thr = THR_W'(4);
            2'd2: narrow_thr = THR_W'(8);
            default: narrow_thr = THR_W'(12);
        endcase
        thr = wide ? (narrow_thr >> 1) : narrow_thr;
    end

    // a_r1_thr_range: every code gives a usable, in-range threshold
    always_comb begin
        a_r1_thr_range: assert (thr != '0 && thr <= THR_W'(MAX_THR));
    end
endmodule

// File: rtl/rx_drain_cnt.sv
module rx_drain_cnt
    import rx_drain_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [THR_W-1:0] load_val,
    output logic             last
);
    logic [THR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - THR_W'(1);
    end

    assign last = (cnt_q == THR_W'(1));

    // a_r5_cnt_step: each counted transfer removes exactly one unit
    a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - THR_W'(1)));
    // a_r5_cnt_load: a burst starts with the full threshold
    a_r5_cnt_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/rx_drain_fsm.sv
module rx_drain_fsm
    import rx_drain_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_mode,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [THR_W-1:0] thr,
    input  logic             xfer_ack,
    input  logic             cnt_last,
    output logic             cnt_load,
    output logic             cnt_dec,
    output logic             bus_req,
    output logic             xfer_en,
    output logic             burst_end
);
    drain_state_e state_q, state_d;
    logic active, fifo_empty, take_last, at_thr;

    assign fifo_empty = (fifo_level == '0);
    assign at_thr     = (fifo_level >= LVL_W'(thr));
    assign active     = (state_q != ST_IDLE);
    // the acknowledged transfer drains the FIFO or completes the block
    assign take_last  = (fifo_level == LVL_W'(1)) || (blk_mode && cnt_last);

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (at_thr) state_d = ST_REQ;
            end
            ST_REQ, ST_BURST: begin
                if (fifo_empty)
                    state_d = ST_IDLE;
                else if (xfer_ack)
                    state_d = take_last ? ST_IDLE : ST_BURST;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        bus_req   = (state_q == ST_REQ);
        xfer_en   = active && !fifo_empty;
        cnt_load  = (state_q == ST_IDLE) && at_thr;
        cnt_dec   = xfer_en && xfer_ack;
        burst_end = active && (fifo_empty || (xfer_ack && take_last));
    end

    // a_r2_raise: threshold reached while idle raises the request next cycle
    a_r2_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && at_thr) |=> bus_req);
    // a_r3_req_held: request stays up until a transfer is acknowledged
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !xfer_ack && !fifo_empty) |=> bus_req);
    // a_r3_req_drop: an acknowledged first transfer drops the request
    a_r3_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && xfer_ack) |=> !bus_req);
    // a_r8_empty_exit: an empty FIFO ends any active burst
    a_r8_empty_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (active && fifo_empty) |=> (state_q == ST_IDLE));
    // a_r9_gap: a finished burst is followed by an idle cycle
    a_r9_gap: assert property (@(posedge clk) disable iff (!rst_n)
        burst_end |=> (state_q == ST_IDLE && !bus_req));
endmodule

// File: rtl/rx_drain_sched.sv
module rx_drain_sched
    import rx_drain_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       thr_sel,
    input  logic             blk_mode,
    input  logic             wide_unit,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             xfer_ack,
    output logic             bus_req,
    output logic             xfer_en,
    output logic             burst_end
);
    logic [THR_W-1:0] thr;
    logic cnt_load, cnt_dec, cnt_last;

    rx_drain_thresh u_thresh (
        .sel  (thr_sel),
        .wide (wide_unit),
        .thr  (thr)
    );

    rx_drain_cnt u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .dec      (cnt_dec),
        .load_val (thr),
        .last     (cnt_last)
    );

    rx_drain_fsm #(.LVL_W(LVL_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .blk_mode   (blk_mode),
        .fifo_level (fifo_level),
        .thr        (thr),
        .xfer_ack   (xfer_ack),
        .cnt_last   (cnt_last),
        .cnt_load   (cnt_load),
        .cnt_dec    (cnt_dec),
        .bus_req    (bus_req),
        .xfer_en    (xfer_en),
        .burst_end  (burst_end)
    );
endmodule

// File: tb/rx_drain_sched_tb.sv
module rx_drain_sched_tb;
    localparam int CLK_P = 10;
    localparam int LVL_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] thr_sel = 2'd0;
    logic blk_mode = 1'b0;
    logic wide_unit = 1'b0;
    logic [LVL_W-1:0] fifo_level = '0;
    logic xfer_ack = 1'b0;
    logic bus_req, xfer_en, burst_end;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    rx_drain_sched #(.LVL_W(LVL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .thr_sel(thr_sel), .blk_mode(blk_mode),
        .wide_unit(wide_unit), .fifo_level(fifo_level), .xfer_ack(xfer_ack),
        .bus_req(bus_req), .xfer_en(xfer_en), .burst_end(burst_end)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_thr(input int code, input bit wide);
        int n;
        n = (code == 3) ? 12 : (2 << code);
        return wide ? n / 2 : n;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; xfer_ack = 1'b0; fifo_level = '0;
        repeat (2) @(posedge clk);
        #1;
        chk("R11 bus_req in reset", int'(bus_req), 0);
        chk("R11 xfer_en in reset", int'(xfer_en), 0);
        chk("R11 burst_end in reset", int'(burst_end), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drives acknowledges while transfers are allowed; mimics FIFO drain
    task automatic run_burst(input int thr, input bit early, output int n);
        bit exp_last;
        n = 0;
        for (int g = 0; g < 100; g++) begin
            @(negedge clk);
            if (!xfer_en) break;
            xfer_ack = 1'b1;
            #1;
            exp_last = (fifo_level == 1) || (blk_mode && (n + 1 == thr));
            chk("R10 burst_end on ack", int'(burst_end), int'(exp_last));
            @(posedge clk);
            #1;
            xfer_ack = 1'b0;
            fifo_level = fifo_level - 1'b1;
            n++;
            chk("R3 bus_req after ack", int'(bus_req), 0);
            if (early && n == 1) fifo_level = LVL_W'(1);
        end
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
                $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        int thr, lvl, n, rem;
        for (int w = 0; w < 2; w++) begin
            for (int c = 0; c < 4; c++) begin
                for (int m = 0; m < 2; m++) begin
                    do_reset();
                    thr_sel = 2'(c); wide_unit = 1'(w); blk_mode = 1'(m);
                    thr = exp_thr(c, 1'(w));
                    // R1/R2: one below the threshold must not request
                    fifo_level = LVL_W'(thr - 1);
                    repeat (3) @(posedge clk);
                    #1;
                    chk("R1 R2 below threshold", int'(bus_req), 0);
                    chk("R4 xfer_en idle", int'(xfer_en), 0);
                    @(negedge clk);
                    lvl = thr + 3;
                    fifo_level = LVL_W'(lvl);
                    @(posedge clk);
                    #1;
                    chk("R1 R2 at threshold", int'(bus_req), 1);
                    repeat (3) @(posedge clk);
                    #1;
                    chk("R3 request held", int'(bus_req), 1);
                    chk("R4 xfer_en in request", int'(xfer_en), 1);
                    run_burst(thr, 1'b0, n);
                    if (m == 1) chk("R5 block burst length", n, thr);
                    else chk("R6 drain burst length", n, lvl);
                    chk("R9 bus_req after burst", int'(bus_req), 0);
                    chk("R4 xfer_en after burst", int'(xfer_en), 0);
                    rem = lvl - n;
                    @(posedge clk);
                    #1;
                    chk("R9 re-request decision", int'(bus_req), int'(rem >= thr));
                    if (rem >= thr) begin
                        @(negedge clk);
                        fifo_level = '0;
                        #1;
                        chk("R8 xfer_en when empty", int'(xfer_en), 0);
                        chk("R8 burst_end when empty", int'(burst_end), 1);
                        @(posedge clk);
                        #1;
                        chk("R8 back to idle", int'(bus_req), 0);
                    end
                    // R7: block burst cut short when the FIFO runs dry
                    if (m == 1 && thr >= 3) begin
                        do_reset();
                        fifo_level = LVL_W'(thr);
                        @(posedge clk);
                        #1;
                        chk("R2 request for early case", int'(bus_req), 1);
                        run_burst(thr, 1'b1, n);
                        chk("R7 early end length", n, 2);
                        chk("R7 xfer_en after early end", int'(xfer_en), 0);
                    end
                end
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule